// File: doc/BRIEF.md
# Transfer Page-Map Address Translator

This block keeps the page map that a disk/tape transfer adapter uses to turn a 17-bit transfer virtual address into a physical memory address. The map has 256 entries. Each entry holds a valid flag and a 21-bit page frame number. Software fills the map through a word-wide register port: one index, one write strobe, and a read bus that always shows the indexed entry. The transfer engine raises a translate request with a virtual address. One cycle later it receives a done strobe, a success flag and the physical address.

Every lookup also loads the raw entry into a selected-map register, which software can read, whether the entry is valid or not. A lookup that hits an entry with a clear valid flag does not return an address. Instead it pulses an invalid-map error toward the adapter's status logic. Because the map has a single lookup path, a software map write takes priority in any cycle where it collides with a request. The request is then parked and retried.

Control is a two-state machine. In `ST_IDLE` a request is looked up at once unless a map write is present in the same cycle. In that case the machine takes transition `PARK` into `ST_HOLD` and keeps the virtual address. In `ST_HOLD` the parked lookup is retried on every cycle. Transition `RETRY` back to `ST_IDLE` is taken on the first cycle without a map write. Transition `FLUSH` goes from either state to `ST_IDLE` when the adapter initialize is asserted.

Top module: `pgmap_xlate`

## Requirements
- R1: A map write stores bit 31 of the data word as the valid flag and bits [20:0] as the page frame. The read bus shows the entry selected by the index as {valid, ten zero bits, frame}, so bits [30:21] always read zero.
- R2: A request accepted in `ST_IDLE` with no map write in the same cycle produces `xl_done` = 1 in the next cycle. For a valid entry it also gives `xl_ok` = 1 and `xl_pa` = {frame, va[8:0]}, which is the frame shifted left by 9 plus the byte offset.
- R3: The map index of a lookup is va[16:9]. The byte offset va[8:0] only passes into the low 9 bits of the physical address.
- R4: Every lookup, valid or not, loads `sel_map` with the raw entry in the R1 format.
- R5: A lookup of an entry whose valid flag is clear gives `xl_ok` = 0 and `xl_pa` = 0, together with a one-cycle `inv_map` pulse in the same cycle as `xl_done`.
- R6: A request in the same cycle as a map write is parked. `xl_busy` rises, no done appears, and the lookup repeats on each later cycle until one has no map write. That cycle's result appears one cycle later and uses the map contents after all the writes.
- R7: Power-up reset (`rst_n` low) clears every map entry, `sel_map` and all result outputs.
- R8: `adp_init` clears `sel_map`, `xl_ok`, `xl_pa` and any parked lookup without producing a done. It leaves map contents unchanged, and a map write in the same cycle still takes effect.
- R9: While `xl_busy` is high, `xl_req` and `xl_va` are ignored, and the parked address is the one translated.
- R10: `xl_done` and `inv_map` are single-cycle pulses that appear only for a lookup. `xl_ok` and `xl_pa` hold their last result between lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| adp_init | input | 1 | Adapter initialize: clears result and pending state, keeps the map |
| map_wr_en | input | 1 | Map entry write strobe |
| map_idx | input | 8 | Map entry index for the register port |
| map_wr_data | input | 32 | Entry write data: bit 31 valid, bits [20:0] frame |
| map_rd_data | output | 32 | Entry at `map_idx`, in the R1 format |
| xl_req | input | 1 | Translate request |
| xl_va | input | 17 | Transfer virtual address |
| xl_busy | output | 1 | A lookup is parked behind map writes |
| xl_done | output | 1 | Result strobe |
| xl_ok | output | 1 | Last lookup hit a valid entry |
| xl_pa | output | 30 | Last translated physical address |
| inv_map | output | 1 | Invalid-map error pulse |
| sel_map | output | 32 | Selected-map register, in the R1 format |

## Verification
The map is loaded with valid entries at distinct indexes, with an invalid entry, and with write data whose reserved bits are set. Translating offsets against these entries shows whether the index and offset fields are split correctly and whether reserved bits are masked. Collisions between map writes and requests are tried with a single write, with several back-to-back writes, and with a write to the very entry being looked up. These show whether the parked address is kept, whether a new request during the wait is ignored, and whether the retry sees the new data. Adapter initialize is applied both idle and while a lookup is parked, and a later power-up reset is applied. Together they separate the state that each of the two clears may touch. A long mix of random writes, requests and initializes is then compared every cycle against a behavioural model.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } lk_state_t;

    localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/pgmap_store.sv
module pgmap_store #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned PFN_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PFN_W-1:0] rd_pfn,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_valid,
    output logic [PFN_W-1:0] lk_pfn
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic             v_q;
        logic [PFN_W-1:0] p_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                p_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                v_q <= wr_valid;
                p_q <= wr_pfn;
            end
        end
        assign valid_vec[e] = v_q;
        assign pfn_vec[e]   = p_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_pfn   = pfn_vec[rd_idx];
    assign lk_valid = valid_vec[lk_idx];
    assign lk_pfn   = pfn_vec[lk_idx];
endmodule

// File: rtl/pgmap_fsm.sv
module pgmap_fsm
    import pgmap_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned OFS_W = 9,
    parameter int unsigned PFN_W = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adp_init,
    input  logic                     map_wr_en,
    input  logic                     xl_req,
    input  logic [IDX_W+OFS_W-1:0]   xl_va,
    output logic [IDX_W-1:0]         lk_idx,
    input  logic                     lk_valid,
    input  logic [PFN_W-1:0]         lk_pfn,
    output logic                     xl_busy,
    output logic                     xl_done,
    output logic                     xl_ok,
    output logic [PFN_W+OFS_W-1:0]   xl_pa,
    output logic                     inv_map,
    output logic                     sel_valid,
    output logic [PFN_W-1:0]         sel_pfn
);
    localparam int unsigned VA_W = IDX_W + OFS_W;
    localparam int unsigned PA_W = PFN_W + OFS_W;

    lk_state_t       state_q;
    logic [VA_W-1:0] held_va_q;
    logic [VA_W-1:0] lk_va;
    logic            fire;

    assign lk_va  = (state_q == ST_HOLD) ? held_va_q : xl_va;
    assign lk_idx = lk_va[VA_W-1:OFS_W];
    assign fire   = !adp_init && !map_wr_en &&
                    (((state_q == ST_IDLE) && xl_req) || (state_q == ST_HOLD));
    assign xl_busy = (state_q == ST_HOLD);

    // State register: PARK, RETRY, FLUSH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            held_va_q <= '0;
        end else if (adp_init) begin
            state_q <= ST_IDLE;                       // FLUSH
        end else begin
            unique case (state_q)
                ST_IDLE: if (xl_req && map_wr_en) begin
                    state_q   <= ST_HOLD;             // PARK
                    held_va_q <= xl_va;
                end
                ST_HOLD: if (!map_wr_en) state_q <= ST_IDLE;  // RETRY
            endcase
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xl_done   <= 1'b0;
            inv_map   <= 1'b0;
            xl_ok     <= 1'b0;
            xl_pa     <= '0;
            sel_valid <= 1'b0;
            sel_pfn   <= '0;
        end else begin
            xl_done <= fire;
            inv_map <= fire && !lk_valid;
            if (adp_init) begin
                xl_ok     <= 1'b0;
                xl_pa     <= '0;
                sel_valid <= 1'b0;
                sel_pfn   <= '0;
            end else if (fire) begin
                sel_valid <= lk_valid;
                sel_pfn   <= lk_pfn;
                xl_ok     <= lk_valid;
                xl_pa     <= lk_valid ? {lk_pfn, lk_va[OFS_W-1:0]} : PA_W'(0);
            end
        end
    end

    assert_inv_with_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_map |-> (xl_done && !xl_ok && (xl_pa == '0)));
    assert_prompt_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!xl_busy && xl_req && !map_wr_en && !adp_init) |=> xl_done);
    assert_write_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!xl_busy && xl_req && map_wr_en && !adp_init) |=> (xl_busy && !xl_done));
    assert_init_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adp_init |=> (!xl_busy && !xl_done && !sel_valid && (sel_pfn == '0)));
    assert_done_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |-> $past(xl_req || xl_busy));
endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
    import pgmap_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned OFS_W = 9,
    parameter int unsigned PFN_W = 21
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adp_init,
    input  logic                       map_wr_en,
    input  logic [IDX_W-1:0]           map_idx,
    input  logic [WORD_W-1:0]          map_wr_data,
    output logic [WORD_W-1:0]          map_rd_data,
    input  logic                       xl_req,
    input  logic [IDX_W+OFS_W-1:0]     xl_va,
    output logic                       xl_busy,
    output logic                       xl_done,
    output logic                       xl_ok,
    output logic [PFN_W+OFS_W-1:0]     xl_pa,
    output logic                       inv_map,
    output logic [WORD_W-1:0]          sel_map
);
    localparam int unsigned GAP_W = WORD_W - 1 - PFN_W;

    logic             rd_valid, lk_valid, sel_valid;
    logic [PFN_W-1:0] rd_pfn, lk_pfn, sel_pfn;
    logic [IDX_W-1:0] lk_idx;
    logic             unused_bits;

    assign unused_bits = ^map_wr_data[WORD_W-2:PFN_W];

    pgmap_store #(.IDX_W(IDX_W), .PFN_W(PFN_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_wr_en),
        .wr_idx   (map_idx),
        .wr_valid (map_wr_data[WORD_W-1]),
        .wr_pfn   (map_wr_data[PFN_W-1:0]),
        .rd_idx   (map_idx),
        .rd_valid (rd_valid),
        .rd_pfn   (rd_pfn),
        .lk_idx   (lk_idx),
        .lk_valid (lk_valid),
        .lk_pfn   (lk_pfn)
    );

    pgmap_fsm #(.IDX_W(IDX_W), .OFS_W(OFS_W), .PFN_W(PFN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .adp_init  (adp_init),
        .map_wr_en (map_wr_en),
        .xl_req    (xl_req),
        .xl_va     (xl_va),
        .lk_idx    (lk_idx),
        .lk_valid  (lk_valid),
        .lk_pfn    (lk_pfn),
        .xl_busy   (xl_busy),
        .xl_done   (xl_done),
        .xl_ok     (xl_ok),
        .xl_pa     (xl_pa),
        .inv_map   (inv_map),
        .sel_valid (sel_valid),
        .sel_pfn   (sel_pfn)
    );

    assign map_rd_data = {rd_valid, {GAP_W{1'b0}}, rd_pfn};
    assign sel_map     = {sel_valid, {GAP_W{1'b0}}, sel_pfn};

    assert_sel_matches_lookup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |-> (sel_map[WORD_W-1] == xl_ok));
    assert_read_gap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (map_rd_data[WORD_W-2:PFN_W] == '0) && (sel_map[WORD_W-2:PFN_W] == '0));
endmodule

// File: tb/pgmap_xlate_test.sv
module pgmap_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adp_init = 1'b0;
    logic        map_wr_en = 1'b0;
    logic [7:0]  map_idx = '0;
    logic [31:0] map_wr_data = '0;
    logic [31:0] map_rd_data;
    logic        xl_req = 1'b0;
    logic [16:0] xl_va = '0;
    logic        xl_busy, xl_done, xl_ok, inv_map;
    logic [29:0] xl_pa;
    logic [31:0] sel_map;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pgmap_xlate uut (
        .clk(clk), .rst_n(rst_n), .adp_init(adp_init), .map_wr_en(map_wr_en),
        .map_idx(map_idx), .map_wr_data(map_wr_data), .map_rd_data(map_rd_data),
        .xl_req(xl_req), .xl_va(xl_va), .xl_busy(xl_busy), .xl_done(xl_done),
        .xl_ok(xl_ok), .xl_pa(xl_pa), .inv_map(inv_map), .sel_map(sel_map)
    );

    // behavioural model
    logic [31:0] m_map [256];
    logic        m_busy, m_done, m_ok, m_inv;
    logic [29:0] m_pa;
    logic [31:0] m_sel;
    logic [16:0] m_held;

    task automatic m_lookup(input logic [16:0] va);
        logic [31:0] e;
        e = m_map[va[16:9]];
        m_sel  = e;
        m_done = 1'b1;
        m_ok   = e[31];
        m_inv  = !e[31];
        m_pa   = e[31] ? {e[20:0], va[8:0]} : 30'd0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_map[i] = 32'd0;
            m_busy = 0; m_done = 0; m_ok = 0; m_inv = 0;
            m_pa = 0; m_sel = 0; m_held = 0;
        end else begin
            m_done = 0;
            m_inv  = 0;
            if (adp_init) begin
                m_busy = 0; m_ok = 0; m_pa = 0; m_sel = 0;
            end else if (m_busy) begin
                if (!map_wr_en) begin
                    m_busy = 0;
                    m_lookup(m_held);
                end
            end else if (xl_req) begin
                if (map_wr_en) begin
                    m_busy = 1;
                    m_held = xl_va;
                end else m_lookup(xl_va);
            end
            if (map_wr_en)
                m_map[map_idx] = map_wr_data & 32'h801F_FFFF;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 done", 64'(xl_done), 64'(m_done));
            chk("R5 inv_map", 64'(inv_map), 64'(m_inv));
            chk("R2 ok", 64'(xl_ok), 64'(m_ok));
            chk("R2 pa", 64'(xl_pa), 64'(m_pa));
            chk("R4 sel_map", 64'(sel_map), 64'(m_sel));
            chk("R6 busy", 64'(xl_busy), 64'(m_busy));
            chk("R1 rd_data", 64'(map_rd_data), 64'(m_map[map_idx]));
        end
    end

    // one cycle of stimulus; returns with outputs of that cycle visible
    task automatic cyc(input logic wr, input logic [7:0] idx, input logic [31:0] d,
                       input logic rq, input logic [16:0] va, input logic ini);
        map_wr_en = wr; map_idx = idx; map_wr_data = d;
        xl_req = rq; xl_va = va; adp_init = ini;
        @(posedge clk); #5;
    endtask

    task automatic idle(input logic [7:0] idx);
        cyc(0, idx, 0, 0, 0, 0);
    endtask

    bit timed_out = 0;
    initial begin
        #(20 * 200000);
        timed_out = 1;
    end

    initial begin
        @(posedge clk); @(posedge clk); @(posedge clk); #5;
        rst_n = 1'b1;
        #1;
        chk("R7 reset rd", 64'(map_rd_data), 0);
        chk("R7 reset sel", 64'(sel_map), 0);
        chk("R7 reset done", 64'(xl_done), 0);

        cyc(1, 8'h03, 32'hFFE1_2345, 0, 0, 0);
        idle(8'h03);
        chk("R1 masked read", 64'(map_rd_data), 64'h8001_2345);
        cyc(1, 8'hFF, 32'h801F_FFFF, 0, 0, 0);
        cyc(1, 8'h10, 32'h0000_0ABC, 0, 0, 0);

        cyc(0, 8'h03, 0, 1, {8'h03, 9'h1A5}, 0);
        chk("R2 done", 64'(xl_done), 1);
        chk("R2 ok", 64'(xl_ok), 1);
        chk("R3 pa", 64'(xl_pa), 64'({21'h12345, 9'h1A5}));
        chk("R4 sel valid", 64'(sel_map), 64'h8001_2345);
        idle(8'h03);
        chk("R10 done drops", 64'(xl_done), 0);
        chk("R10 pa held", 64'(xl_pa), 64'({21'h12345, 9'h1A5}));

        cyc(0, 8'h00, 0, 1, {8'hFF, 9'h1FF}, 0);
        chk("R2 max pa", 64'(xl_pa), 64'h3FFF_FFFF);

        cyc(0, 8'h00, 0, 1, {8'h10, 9'h001}, 0);
        chk("R5 ok", 64'(xl_ok), 0);
        chk("R5 inv", 64'(inv_map), 1);
        chk("R5 pa", 64'(xl_pa), 0);
        chk("R4 sel invalid", 64'(sel_map), 64'h0000_0ABC);
        idle(8'h00);
        chk("R5 inv pulse", 64'(inv_map), 0);

        cyc(1, 8'h20, 32'h8000_0077, 1, {8'h20, 9'h005}, 0);
        chk("R6 parked busy", 64'(xl_busy), 1);
        chk("R6 no done", 64'(xl_done), 0);
        cyc(1, 8'h21, 32'h8000_0099, 1, {8'h21, 9'h000}, 0);
        chk("R9 still busy", 64'(xl_busy), 1);
        chk("R9 no done", 64'(xl_done), 0);
        idle(8'h20);
        chk("R6 retry done", 64'(xl_done), 1);
        chk("R9 held va", 64'(xl_pa), 64'({21'h77, 9'h005}));
        chk("R6 busy clear", 64'(xl_busy), 0);

        cyc(0, 8'h03, 0, 0, 0, 1);
        chk("R8 sel cleared", 64'(sel_map), 0);
        chk("R8 map kept", 64'(map_rd_data), 64'h8001_2345);
        cyc(1, 8'h30, 32'h8000_0001, 1, {8'h30, 9'h0}, 0);
        cyc(0, 8'h30, 0, 0, 0, 1);
        chk("R8 pending dropped", 64'(xl_busy), 0);
        idle(8'h30);
        chk("R8 no late done", 64'(xl_done), 0);
        chk("R8 write kept", 64'(map_rd_data), 64'h8000_0001);

        void'($urandom(7));
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] & r[1], {5'b0, r[4:2]}, $urandom, r[5] | r[6],
                {5'b0, r[9:7], r[20:12]}, (r[11:10] == 2'b11) && r[21]);
        end

        cyc(1, 8'h03, 32'h8000_0055, 0, 0, 0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #5;
        rst_n = 1'b1;
        map_idx = 8'h03;
        #1;
        chk("R7 map cleared", 64'(map_rd_data), 0);
        chk("R7 sel cleared", 64'(sel_map), 0);
        idle(8'h03);
        idle(8'h03);
        finish_run();
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge timed_out) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end
endmodule